// File: doc/BRIEF.md
# Chainable 16-bit SPI Command and Status Slave

This block is the serial front end of a control device. A host lowers chip select, clocks command bits into `si` on the rising edge of `sclk`, and reads a status word from `so`, which changes on the falling edge. When chip select drops, the output shifter is loaded with a status word. That word is built from the last accepted command, the mode input and whichever internal register the sticky status selection points at. Once 16 bits have gone out, `so` repeats what entered `si`, 16 clocks later. This lets several devices share one chip select in a chain.

A frame counts only if its length is a non-zero multiple of 16 bits. In that case the last 16 bits received are the command, and they are committed when chip select rises. Any other frame is dropped without trace. The block owns a small per-channel register file, a per-channel sticky fault latch that is frozen while a frame is open, and a flag that tells the host a frame was taken under low supply. The SPI pins are oversampled in the `clk` domain. `soOe` is the enable for the pad that drives `so`.

Top module: `spi_reg_slave`

## Requirements
- R1: While chip select is high, `soOe` is 0 and `so` is 0. In a frame `soOe` is 1. After reset no frame is open and every register reads 0.
- R2: When chip select falls, the first 16 bits on `so` go out MSB first. Bit 15 is bit 15 of the last accepted command, bits 14:10 are that command's address bits 14:10, bit 9 is `normalMode` at the fall, and bits 8:0 are the selected source.
- R3: From the 17th bit of a frame on, `so` carries the bits that entered `si` in the same frame, delayed by 16 `sclk` periods.
- R4: A frame is accepted only when its bit count is a non-zero multiple of 16. The last 16 bits received before chip select rises form the command.
- R5: A rejected frame (zero length, or any length that is not a multiple of 16) changes no register, no fault latch and no later status word.
- R6: The command layout is bit 15 watchdog, bits 14:10 address, bit 9 channel, bits 8:0 data. Addresses 1 to NUM_REG write `data` into register (channel, address−1), which `regOut` shows at bit offset ((channel·NUM_REG)+address−1)·9. Addresses above NUM_REG write nothing, but they still count as the last accepted command.
- R7: Address 0 is the status selector. Data bits 2:0 give the source code and bit 9 gives the channel, and both persist until the next address-0 write. Code 0 shows the fault latch of that channel, code k (1..NUM_REG) shows register (channel, k−1), and any other code shows 0.
- R8: Each channel's 9-bit fault latch collects `faultIn` bits while no frame is open and holds still while a frame is open.
- R9: When an accepted frame commits while the selector points at a channel's fault latch, that latch is reloaded from the current `faultIn`. Events that are present in the commit cycle are kept.
- R10: `statusInvalid` takes the value of `lowSupply` at the chip-select fall, holds it through the frame, and is 0 while chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the SPI pins |
| rstN | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the host (idle low) |
| csb | input | 1 | Active-low chip select |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out, 0 when not enabled |
| soOe | output | 1 | Output enable for the `so` pad driver |
| normalMode | input | 1 | Device in normal mode; reported in status bit 9 |
| lowSupply | input | 1 | Supply below its valid level |
| faultIn | input | 2·9 | Fault events, channel c at bits c·9 +: 9 |
| regOut | output | 2·NUM_REG·9 | Register file contents for the rest of the device |
| statusInvalid | output | 1 | The status word now shifting was taken under low supply |

## Verification
Two things can land in the same `clk` cycle: a frame commit that reloads a fault latch (the clear-on-read), and a fault event that arrives at that moment. The bench provokes this by holding a fault input active across the end of a frame that reads that latch. It judges the outcome by the status word of the next frame, which must still show the event. A fault pulse that lives only inside an open frame, and reads through rejected frames, are checked the same way, through the next returned word.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;
  localparam int WORD_W = 16;
  localparam int DATA_W = 9;
  localparam int ADDR_W = 5;
  localparam int NUM_CH = 2;
  localparam int SEL_W  = 3;
  localparam int CH_BIT = DATA_W;
  localparam int ADDR_LSB = DATA_W + 1;
  localparam int CNT_W = $clog2(WORD_W);

  typedef struct packed {
    logic loadTx;
    logic sampleRx;
    logic shiftTx;
    logic frameEnd;
    logic commit;
    logic siBit;
  } strobeT;
endpackage

// File: rtl/spi_frame_ctrl.sv
module spi_frame_ctrl
  import spi_reg_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   sclk,
  input  logic   csb,
  input  logic   si,
  output strobeT stb,
  output logic   frameOpen
);
  logic sclkQ, sclkQ2, csbQ, csbQ2, siQ;
  logic [CNT_W-1:0] bitMod;
  logic anyBits;
  logic csbFall, csbRise, sclkRise, sclkFall;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkQ  <= 1'b0;
      sclkQ2 <= 1'b0;
      csbQ   <= 1'b1;
      csbQ2  <= 1'b1;
      siQ    <= 1'b0;
    end else begin
      sclkQ  <= sclk;
      sclkQ2 <= sclkQ;
      csbQ   <= csb;
      csbQ2  <= csbQ;
      siQ    <= si;
    end
  end

  assign csbFall  = !csbQ && csbQ2;
  assign csbRise  = csbQ && !csbQ2;
  assign sclkRise = sclkQ && !sclkQ2;
  assign sclkFall = !sclkQ && sclkQ2;

  always_comb begin
    stb.loadTx   = csbFall;
    stb.sampleRx = frameOpen && !csbQ && sclkRise;
    stb.shiftTx  = frameOpen && !csbQ && sclkFall;
    stb.frameEnd = frameOpen && csbRise;
    stb.commit   = frameOpen && csbRise && anyBits && (bitMod == '0);
    stb.siBit    = siQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameOpen <= 1'b0;
      bitMod    <= '0;
      anyBits   <= 1'b0;
    end else begin
      if (csbFall) begin
        frameOpen <= 1'b1;
        bitMod    <= '0;
        anyBits   <= 1'b0;
      end else if (csbRise) begin
        frameOpen <= 1'b0;
      end else if (stb.sampleRx) begin
        bitMod  <= bitMod + 1'b1;
        anyBits <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/spi_reg_datapath.sv
module spi_reg_datapath
  import spi_reg_pkg::*;
#(
  parameter int NUM_REG = 3
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  strobeT                        stb,
  input  logic                          frameOpen,
  input  logic                          normalMode,
  input  logic                          lowSupply,
  input  logic [NUM_CH*DATA_W-1:0]      faultIn,
  output logic                          so,
  output logic                          statusInvalid,
  output logic [NUM_CH*NUM_REG*DATA_W-1:0] regOut
);
  logic [WORD_W-1:0] rxSh, txSh, prevCmd;
  logic [SEL_W-1:0]  selCode;
  logic              selCh;
  logic [DATA_W-1:0] regs     [NUM_CH][NUM_REG];
  logic [DATA_W-1:0] faultLat [NUM_CH];
  logic [DATA_W-1:0] selData;
  logic [WORD_W-1:0] statusWord;
  logic [ADDR_W-1:0] cmdAddr;
  logic              cmdCh;

  assign cmdAddr = rxSh[ADDR_LSB +: ADDR_W];
  assign cmdCh   = rxSh[CH_BIT];

  // Source picked by the sticky selector
  always_comb begin
    selData = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (selCh == 1'(c) && selCode == '0) selData = faultLat[c];
      for (int r = 0; r < NUM_REG; r++)
        if (selCh == 1'(c) && selCode == SEL_W'(r + 1)) selData = regs[c][r];
    end
  end

  assign statusWord = {prevCmd[WORD_W-1], prevCmd[ADDR_LSB +: ADDR_W], normalMode, selData};
  assign so = frameOpen & txSh[WORD_W-1];

  // Shift paths: receive, and transmit with 16-bit echo delay
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxSh          <= '0;
      txSh          <= '0;
      statusInvalid <= 1'b0;
    end else begin
      if (stb.sampleRx) rxSh <= {rxSh[WORD_W-2:0], stb.siBit};
      if (stb.loadTx) txSh <= statusWord;
      else if (stb.shiftTx) txSh <= {txSh[WORD_W-2:0], rxSh[0]};
      if (stb.loadTx) statusInvalid <= lowSupply;
      else if (stb.frameEnd) statusInvalid <= 1'b0;
    end
  end

  // Commit of an accepted command, register file and fault latches
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevCmd <= '0;
      selCode <= '0;
      selCh   <= 1'b0;
      for (int c = 0; c < NUM_CH; c++) begin
        faultLat[c] <= '0;
        for (int r = 0; r < NUM_REG; r++) regs[c][r] <= '0;
      end
    end else begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (stb.commit && selCode == '0 && selCh == 1'(c))
          faultLat[c] <= faultIn[c*DATA_W +: DATA_W];
        else if (!frameOpen)
          faultLat[c] <= faultLat[c] | faultIn[c*DATA_W +: DATA_W];
      end
      if (stb.commit) begin
        prevCmd <= rxSh;
        if (cmdAddr == '0) begin
          selCode <= rxSh[SEL_W-1:0];
          selCh   <= cmdCh;
        end
        for (int c = 0; c < NUM_CH; c++)
          for (int r = 0; r < NUM_REG; r++)
            if (cmdCh == 1'(c) && cmdAddr == ADDR_W'(r + 1))
              regs[c][r] <= rxSh[DATA_W-1:0];
      end
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    for (genvar r = 0; r < NUM_REG; r++) begin : g_reg
      assign regOut[(c*NUM_REG + r)*DATA_W +: DATA_W] = regs[c][r];
    end
  end
endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave
  import spi_reg_pkg::*;
#(
  parameter int NUM_REG = 3
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             sclk,
  input  logic                             csb,
  input  logic                             si,
  output logic                             so,
  output logic                             soOe,
  input  logic                             normalMode,
  input  logic                             lowSupply,
  input  logic [NUM_CH*DATA_W-1:0]         faultIn,
  output logic [NUM_CH*NUM_REG*DATA_W-1:0] regOut,
  output logic                             statusInvalid
);
  strobeT stb;
  logic   frameOpen;

  spi_frame_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .sclk(sclk), .csb(csb), .si(si),
    .stb(stb), .frameOpen(frameOpen)
  );

  spi_reg_datapath #(.NUM_REG(NUM_REG)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .frameOpen(frameOpen),
    .normalMode(normalMode), .lowSupply(lowSupply), .faultIn(faultIn),
    .so(so), .statusInvalid(statusInvalid), .regOut(regOut)
  );

  assign soOe = frameOpen;
endmodule

// File: rtl/spi_reg_checker.sv
module spi_reg_checker #(
  parameter int REGS_W = 54
) (
  input logic              clk,
  input logic              rstN,
  input logic              csb,
  input logic              soOe,
  input logic [REGS_W-1:0] regOut,
  input logic              statusInvalid
);
  // R1: a chip select held high closes the output
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    (csb && $past(csb) && $past(csb, 2)) |-> !soOe);

  // R2: the output opens only after chip select was seen low
  p_open_after_fall_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(soOe) |-> !$past(csb, 2));

  // R4: register writes occur only after chip select has risen
  p_write_at_end_r4: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(regOut) |-> $past(csb, 2));

  // R6: a register write needs a frame that was open
  p_write_needs_frame_r6: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(regOut) |-> $past(soOe));

  // R10: the supply flag lives only inside a frame
  p_flag_in_frame_r10: assert property (@(posedge clk) disable iff (!rstN)
    statusInvalid |-> soOe);

  p_flag_rises_with_frame_r10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusInvalid) |-> $rose(soOe));
endmodule

bind spi_reg_slave spi_reg_checker #(.REGS_W(spi_reg_pkg::NUM_CH*NUM_REG*spi_reg_pkg::DATA_W)) chk_i (
  .clk(clk), .rstN(rstN), .csb(csb), .soOe(soOe),
  .regOut(regOut), .statusInvalid(statusInvalid)
);

// File: tb/spi_reg_slave_tb.sv
module spi_reg_slave_tb_top;
  localparam int NREG = 3;
  localparam int DW = 9;
  localparam int NV = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclk = 1'b0, csb = 1'b1, si = 1'b0;
  logic normalMode = 1'b1, lowSupply = 1'b0;
  logic [2*DW-1:0] faultIn = '0;
  logic so, soOe, statusInvalid;
  logic [2*NREG*DW-1:0] regOut;

  int checks = 0, failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  spi_reg_slave #(.NUM_REG(NREG)) dut_i (
    .clk(clk), .rstN(rstN), .sclk(sclk), .csb(csb), .si(si), .so(so),
    .soOe(soOe), .normalMode(normalMode), .lowSupply(lowSupply),
    .faultIn(faultIn), .regOut(regOut), .statusInvalid(statusInvalid)
  );

  // Reference model kept from the requirements
  logic [15:0] mPrev = '0;
  logic [2:0]  mSelCode = '0;
  logic        mSelCh = 1'b0;
  logic [DW-1:0] mRegs [2][NREG];
  logic [DW-1:0] mFault [2];

  logic [47:0] gotBits;
  logic oeDuring, invDuring;

  // {length, bits right-aligned}; command = {wd, addr[4:0], ch, data[8:0]}
  localparam logic [53:0] VEC [NV] = '{
    {6'd16, 32'd0, 1'b1, 5'd1, 1'b0, 9'h0A5},
    {6'd16, 32'd0, 1'b0, 5'd2, 1'b1, 9'h155},
    {6'd16, 32'd0, 1'b0, 5'd0, 1'b1, 9'd2},
    {6'd16, 32'd0, 1'b1, 5'd3, 1'b0, 9'h1FF},
    {6'd32, 16'd0, 16'h1234, 1'b0, 5'd1, 1'b1, 9'h033},
    {6'd8,  40'd0, 8'hAB},
    {6'd20, 28'd0, 20'hF0F0F},
    {6'd16, 32'd0, 1'b0, 5'd7, 1'b0, 9'h111},
    {6'd16, 32'd0, 1'b1, 5'd0, 1'b0, 9'd1},
    {6'd48, 16'hBEEF, 16'h0001, 1'b1, 5'd2, 1'b0, 9'h0F0},
    {6'd16, 32'd0, 1'b0, 5'd0, 1'b0, 9'd5},
    {6'd16, 32'd0, 1'b0, 5'd0, 1'b0, 9'd0}
  };

  function automatic logic [15:0] expWord(input logic mode);
    logic [DW-1:0] d;
    d = '0;
    if (mSelCode == 3'd0) d = mFault[mSelCh];
    else if (mSelCode <= 3'(NREG)) d = mRegs[mSelCh][mSelCode-1];
    return {mPrev[15:10], mode, d};
  endfunction

  task automatic modelCommit(input logic [15:0] cmd);
    if (mSelCode == 3'd0) mFault[mSelCh] = faultIn[mSelCh*DW +: DW];
    mPrev = cmd;
    if (cmd[14:10] == 5'd0) begin
      mSelCode = cmd[2:0];
      mSelCh = cmd[9];
    end else if (cmd[14:10] <= 5'(NREG)) begin
      mRegs[cmd[9]][cmd[14:10]-1] = cmd[8:0];
    end
  endtask

  task automatic check(input bit ok, input string req, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic spiFrame(input int n, input logic [47:0] bits);
    gotBits = '0;
    @(negedge clk) csb = 1'b0;
    repeat (4) @(negedge clk);
    oeDuring = soOe;
    invDuring = statusInvalid;
    for (int i = 0; i < n; i++) begin
      si = bits[n-1-i];
      gotBits[n-1-i] = so;
      sclk = 1'b1;
      repeat (4) @(negedge clk);
      sclk = 1'b0;
      repeat (4) @(negedge clk);
    end
    csb = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic checkRegs(input string req);
    logic ok;
    logic [47:0] a, e;
    ok = 1'b1; a = '0; e = '0;
    for (int c = 0; c < 2; c++)
      for (int r = 0; r < NREG; r++)
        if (regOut[(c*NREG + r)*DW +: DW] !== mRegs[c][r]) begin
          ok = 1'b0;
          a = 48'(regOut[(c*NREG + r)*DW +: DW]);
          e = 48'(mRegs[c][r]);
        end
    check(ok, req, a, e);
  endtask

  task automatic wordFrame(input logic [15:0] cmd, input logic [DW-1:0] expData, input string req);
    logic [15:0] e;
    e = expWord(normalMode);
    spiFrame(16, {32'd0, cmd});
    check(gotBits[15:0] === e && e[8:0] === expData, req, 48'(gotBits[15:0]), 48'(e));
    modelCommit(cmd);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 2; c++) begin
      mFault[c] = '0;
      for (int r = 0; r < NREG; r++) mRegs[c][r] = '0;
    end
    repeat (5) @(negedge clk);
    // R1: reset state
    check(soOe === 1'b0 && so === 1'b0, "R1 reset idle", {46'd0, soOe, so}, 48'd0);
    check(regOut === '0 && statusInvalid === 1'b0, "R1 reset regs", 48'(regOut), 48'd0);
    rstN = 1'b1;
    repeat (5) @(negedge clk);

    // Table of frames against the model
    for (int v = 0; v < NV; v++) begin
      int n;
      logic [47:0] bits;
      logic [15:0] e;
      logic okW, okE;
      n = int'(VEC[v][53:48]);
      bits = VEC[v][47:0];
      normalMode = (v != 3);
      e = expWord(normalMode);
      spiFrame(n, bits);
      okW = 1'b1;
      for (int j = 0; j < 16 && j < n; j++)
        if (gotBits[n-1-j] !== e[15-j]) okW = 1'b0;
      check(okW, "R2 status word", gotBits, 48'(e));
      if (n > 16) begin
        okE = 1'b1;
        for (int j = 16; j < n; j++)
          if (gotBits[n-1-j] !== bits[n-1-j+16]) okE = 1'b0;
        check(okE, "R3 echo", gotBits, bits);
      end
      check(oeDuring === 1'b1 && soOe === 1'b0 && so === 1'b0, "R1 enable", {45'd0, oeDuring, soOe, so}, 48'd4);
      if (n > 0 && n % 16 == 0) modelCommit(bits[15:0]);
      checkRegs((n % 16 == 0) ? "R4 R6 R7 commit" : "R5 rejected frame");
    end
    normalMode = 1'b1;

    // Selector now shows channel 0 fault latch (code 0)
    @(negedge clk) faultIn = {9'd0, 9'h005};
    repeat (4) @(negedge clk);
    faultIn = '0;
    mFault[0] = 9'h005;
    repeat (4) @(negedge clk);
    // R5: rejected frames do not clear the latch
    spiFrame(8, 48'h3C);
    // R8: fault pulse that exists only inside an open frame is not latched
    @(negedge clk) csb = 1'b0;
    repeat (6) @(negedge clk);
    faultIn = {9'd0, 9'h100};
    repeat (4) @(negedge clk);
    faultIn = '0;
    repeat (4) @(negedge clk);
    csb = 1'b1;
    repeat (6) @(negedge clk);
    wordFrame({1'b0, 5'd0, 1'b0, 9'd0}, 9'h005, "R5 R8 fault held");
    // R9: read cleared the latch
    wordFrame({1'b0, 5'd0, 1'b0, 9'd0}, 9'h000, "R9 cleared on read");
    // R9: event present at commit survives the reload
    @(negedge clk) faultIn = {9'd0, 9'h0C0};
    mFault[0] = 9'h0C0;
    repeat (4) @(negedge clk);
    wordFrame({1'b0, 5'd0, 1'b0, 9'd0}, 9'h0C0, "R8 sticky");
    faultIn = '0;
    wordFrame({1'b0, 5'd0, 1'b0, 9'd0}, 9'h0C0, "R9 same cycle event kept");
    wordFrame({1'b0, 5'd0, 1'b1, 9'd0}, 9'h000, "R9 reload after release");
    // R7: channel 1 fault latch via selector channel bit
    @(negedge clk) faultIn = {9'h021, 9'd0};
    repeat (3) @(negedge clk);
    faultIn = '0;
    mFault[1] = 9'h021;
    wordFrame({1'b0, 5'd0, 1'b1, 9'd1}, 9'h021, "R7 channel 1 fault");
    wordFrame({1'b0, 5'd0, 1'b0, 9'd0}, 9'h033, "R7 channel 1 register");

    // R10: low supply flag
    lowSupply = 1'b1;
    spiFrame(16, 48'd0);
    check(invDuring === 1'b1 && statusInvalid === 1'b0, "R10 flag", {46'd0, invDuring, statusInvalid}, 48'd2);
    lowSupply = 1'b0;
    spiFrame(16, 48'd0);
    check(invDuring === 1'b0, "R10 flag clear", 48'(invDuring), 48'd0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule